// File: doc/BRIEF.md
# Programmable Parallel Port Controller (Basic Mode)

A byte-wide peripheral on a processor bus that exposes 24 general-purpose pins as three 8-bit ports: A, B and C. Port C is split into two nibbles. Group A is port A plus the upper nibble of port C. Group B is port B plus the lower nibble of port C. A chip select gates every access. Two address bits pick one of the three port data registers or the command register.

A byte written to the command register has one of two meanings, chosen by its bit 7. With bit 7 set, the byte is a mode byte: it sets the direction of each port and nibble, and the operating mode of each group. With bit 7 clear, the byte sets or clears one port-C bit. This block carries the simple mode, in which output pins hold a written latch and input pins are read straight through. It decodes and exports the group modes for a separate handshake block. Tristate drivers are represented by per-pin output enables.

Top module: `parallel_port_ctrl`

## Requirements
- R1: After reset, all output enables are 0, all output latches are 0, the group modes are 0, and a read of the command register returns 0x9B.
- R2: Address 2'b00 selects port A, 2'b01 port B, 2'b10 port C and 2'b11 the command register. A write to one port leaves the other ports' latches unchanged.
- R3: A command write with bit 7 = 1 is a mode byte. Its fields are: group A mode in bits 6:5, where 00 is mode 0, 01 is mode 1, and 1x is mode 2 (stored as 10); port A input in bit 4; upper port C input in bit 3; group B mode in bit 2; port B input in bit 1; lower port C input in bit 0. A read of the command register returns {1, stored fields}.
- R4: Every mode byte write clears all three output latches on the same clock edge.
- R5: For a port or nibble configured as output (its input bit = 0), the output enables are all 1. A data write appears on the output pins after the clock edge that samples it.
- R6: A read of a port configured as input returns the current pin inputs combinationally, with no register in the path.
- R7: The two port-C nibbles follow their own direction bits. A port-C read merges pin data for the input nibble with latch data for the output nibble.
- R8: A command write with bit 7 = 0 changes only the port-C bit indexed by bits 3:1, writing it with bit 0. The configuration, the output enables and the latches of ports A and B are left unchanged.
- R9: A read of an output-configured port returns its latch, not its pin inputs, and changes no state.
- R10: With chip select low, writes change nothing and rdata_o is 0. rdata_o is also 0 whenever no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C output enables |
| mode_a_o | output | 2 | Group A mode (0, 1 or 2) |
| mode_b_o | output | 1 | Group B mode (0 or 1) |

## Verification
Writes take effect at the first rising edge at which cs_i and wr_i are high. Latches, enables and modes are therefore due one edge after the write is presented. Reads are combinational and are due in the same cycle as the strobe. The bench changes inputs on falling edges and holds each write for exactly one rising edge. It checks written results after the next falling edge. It samples read data a few nanoseconds after raising the read strobe, inside that same low clock phase.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned IDXW = $clog2(DW);

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CMD = 2'b11
  } sel_e;

  typedef struct packed {
    logic [1:0] mode_a;
    logic       a_in;
    logic       cu_in;
    logic       mode_b;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RST = '{mode_a: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                               mode_b: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic logic [DW-1:0] cfg_to_byte(cfg_t c);
    return {1'b1, c.mode_a, c.a_in, c.cu_in, c.mode_b, c.b_in, c.cl_in};
  endfunction
endpackage

// File: rtl/ppc_cmd_decode.sv
module ppc_cmd_decode
  import ppc_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_wr_i,
  input  logic [W-1:0] wdata_i,
  output cfg_t         cfg_o,
  output logic         mode_load_o,
  output logic [W-1:0] bit_we_o,
  output logic         bit_val_o
);
  localparam int unsigned IW = $clog2(W);

  logic       is_mode;
  logic [IW-1:0] bit_idx;

  assign is_mode     = wdata_i[W-1];
  assign mode_load_o = cmd_wr_i & is_mode;
  assign bit_idx     = wdata_i[IW:1];
  assign bit_val_o   = wdata_i[0];

  always_comb begin
    bit_we_o = '0;
    if (cmd_wr_i && !is_mode) bit_we_o[bit_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= CFG_RST;
    end else if (mode_load_o) begin
      // 1x in the group A field folds to mode 2
      cfg_o.mode_a <= wdata_i[6] ? 2'b10 : {1'b0, wdata_i[5]};
      cfg_o.a_in   <= wdata_i[4];
      cfg_o.cu_in  <= wdata_i[3];
      cfg_o.mode_b <= wdata_i[2];
      cfg_o.b_in   <= wdata_i[1];
      cfg_o.cl_in  <= wdata_i[0];
    end
  end
endmodule

// File: rtl/ppc_port.sv
module ppc_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic [W-1:0] bit_we_i,
  input  logic         bit_val_i,
  input  logic         dir_in_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] latch_q, latch_d;

  always_comb begin
    latch_d = latch_q;
    if (clr_i)       latch_d = '0;
    else if (load_i) latch_d = load_data_i;
    else begin
      for (int i = 0; i < int'(W); i++)
        if (bit_we_i[i]) latch_d[i] = bit_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= latch_d;
  end

  assign pin_o = latch_q;
  assign oe_o  = {W{~dir_in_i}};
  assign rd_o  = dir_in_i ? pin_i : latch_q;
endmodule

// File: rtl/parallel_port_ctrl.sv
module parallel_port_ctrl
  import ppc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o,
  output logic [1:0]    mode_a_o,
  output logic          mode_b_o
);
  localparam int unsigned HW = DW / 2;

  cfg_t          cfg;
  logic          wr_stb, rd_stb, mode_load, bit_val;
  logic [DW-1:0] bit_we, rd_a, rd_b, rd_c;

  assign wr_stb = cs_i & wr_i;
  assign rd_stb = cs_i & rd_i;

  ppc_cmd_decode #(.W(DW)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (wr_stb && addr_i == SEL_CMD),
    .wdata_i    (wdata_i),
    .cfg_o      (cfg),
    .mode_load_o(mode_load),
    .bit_we_o   (bit_we),
    .bit_val_o  (bit_val)
  );

  ppc_port #(.W(DW)) u_pa (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_load),
    .load_i(wr_stb && addr_i == SEL_A), .load_data_i(wdata_i),
    .bit_we_i('0), .bit_val_i(1'b0), .dir_in_i(cfg.a_in),
    .pin_i(pa_i), .pin_o(pa_o), .oe_o(pa_oe_o), .rd_o(rd_a)
  );

  ppc_port #(.W(DW)) u_pb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_load),
    .load_i(wr_stb && addr_i == SEL_B), .load_data_i(wdata_i),
    .bit_we_i('0), .bit_val_i(1'b0), .dir_in_i(cfg.b_in),
    .pin_i(pb_i), .pin_o(pb_o), .oe_o(pb_oe_o), .rd_o(rd_b)
  );

  // Port C: lower nibble belongs to group B, upper to group A
  for (genvar h = 0; h < 2; h++) begin : g_pc
    localparam int unsigned LO = h * HW;
    ppc_port #(.W(HW)) u_half (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_load),
      .load_i(wr_stb && addr_i == SEL_C), .load_data_i(wdata_i[LO +: HW]),
      .bit_we_i(bit_we[LO +: HW]), .bit_val_i(bit_val),
      .dir_in_i(h == 1 ? cfg.cu_in : cfg.cl_in),
      .pin_i(pc_i[LO +: HW]), .pin_o(pc_o[LO +: HW]),
      .oe_o(pc_oe_o[LO +: HW]), .rd_o(rd_c[LO +: HW])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_stb) begin
      unique case (addr_i)
        SEL_A:   rdata_o = rd_a;
        SEL_B:   rdata_o = rd_b;
        SEL_C:   rdata_o = rd_c;
        default: rdata_o = cfg_to_byte(cfg);
      endcase
    end
  end

  assign mode_a_o = cfg.mode_a;
  assign mode_b_o = cfg.mode_b;
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker
  import ppc_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] pa_i,
  input logic [DW-1:0] pa_o,
  input logic [DW-1:0] pa_oe_o,
  input logic [DW-1:0] pb_o,
  input logic [DW-1:0] pb_oe_o,
  input logic [DW-1:0] pc_o,
  input logic [DW-1:0] pc_oe_o,
  input logic [1:0]    mode_a_o,
  input logic          mode_b_o
);
  logic cmd_wr;
  assign cmd_wr = cs_i && wr_i && addr_i == 2'b11;

  a_r4_mode_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && wdata_i[DW-1] |=> pa_o == '0 && pb_o == '0 && pc_o == '0);

  a_r5_dir_out_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && wdata_i[DW-1] && !wdata_i[4] |=> pa_oe_o == '1);

  a_r5_porta_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i && wr_i && addr_i == 2'b00 |=> pa_o == $past(wdata_i));

  a_r8_bit_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && !wdata_i[DW-1] |=> pc_o[$past(wdata_i[IDXW:1])] == $past(wdata_i[0]));

  a_r8_others_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && !wdata_i[DW-1] |=> $stable(pa_o) && $stable(pb_o) && $stable(pa_oe_o)
      && $stable(pb_oe_o) && $stable(pc_oe_o) && $stable(mode_a_o) && $stable(mode_b_o));

  a_r8_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && !wdata_i[DW-1] |=> $countones(pc_o ^ $past(pc_o)) <= 1);

  a_r10_cs_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(pa_o) && $stable(pb_o) && $stable(pc_o) && $stable(pa_oe_o)
      && $stable(pb_oe_o) && $stable(pc_oe_o));

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> rdata_o == '0);

  a_r6_input_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i && rd_i && addr_i == 2'b00 && pa_oe_o == '0 |-> rdata_o == pa_i);

  a_r3_mode_a_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_a_o != 2'b11);
endmodule

bind parallel_port_ctrl ppc_checker u_ppc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .wr_i(wr_i), .rd_i(rd_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .pa_i(pa_i),
  .pa_o(pa_o), .pa_oe_o(pa_oe_o), .pb_o(pb_o), .pb_oe_o(pb_oe_o),
  .pc_o(pc_o), .pc_oe_o(pc_oe_o), .mode_a_o(mode_a_o), .mode_b_o(mode_b_o)
);

// File: tb/parallel_port_ctrl_test.sv
`timescale 1ns/1ps
module parallel_port_ctrl_test;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cs_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;
  logic [1:0] mode_a_o;
  logic       mode_b_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  parallel_port_ctrl uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk_i);
    cs_i = sel; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk_i);
    cs_i = sel; rd_i = 1'b1; addr_i = a;
    #3 d = rdata_o;
    @(negedge clk_i);
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pa_oe", pa_oe_o, 8'h00);
    check("R1 pb_oe", pb_oe_o, 8'h00);
    check("R1 pc_oe", pc_oe_o, 8'h00);
    check("R1 pa_o", pa_o | pb_o | pc_o, 8'h00);
    check("R1 modes", {mode_a_o, 5'd0, mode_b_o}, 8'h00);
    bus_rd(2'b11, d);
    check("R1 cmd read", d, 8'h9B);
    pa_i = 8'h5A;
    bus_rd(2'b00, d);
    check("R6 input read A", d, 8'h5A);
    pb_i = 8'hC3;
    bus_rd(2'b01, d);
    check("R6 input read B", d, 8'hC3);
  endtask

  task automatic t_outputs();
    logic [7:0] d;
    bus_wr(2'b11, 8'h80);
    check("R5 pa_oe", pa_oe_o, 8'hFF);
    check("R5 pb_oe", pb_oe_o, 8'hFF);
    check("R5 pc_oe", pc_oe_o, 8'hFF);
    bus_wr(2'b00, 8'h3C);
    check("R5 pa_o", pa_o, 8'h3C);
    bus_wr(2'b01, 8'hA5);
    check("R2 pb_o", pb_o, 8'hA5);
    check("R2 pa kept", pa_o, 8'h3C);
    bus_wr(2'b10, 8'h81);
    check("R2 pc_o", pc_o, 8'h81);
    pa_i = 8'h11;
    bus_rd(2'b00, d);
    check("R9 read latch A", d, 8'h3C);
    check("R9 no side effect", pa_o, 8'h3C);
  endtask

  task automatic t_mode_clear();
    bus_wr(2'b11, 8'h80);
    check("R4 pa cleared", pa_o, 8'h00);
    check("R4 pb cleared", pb_o, 8'h00);
    check("R4 pc cleared", pc_o, 8'h00);
  endtask

  task automatic t_portc_split();
    logic [7:0] d;
    bus_wr(2'b11, 8'h88);
    check("R7 oe upper in", pc_oe_o, 8'h0F);
    bus_wr(2'b10, 8'hFF);
    pc_i = 8'hA0;
    bus_rd(2'b10, d);
    check("R7 mixed read", d, 8'hAF);
    bus_wr(2'b11, 8'h81);
    check("R7 oe lower in", pc_oe_o, 8'hF0);
    check("R4 pc cleared", pc_o, 8'h00);
    bus_wr(2'b10, 8'hFF);
    pc_i = 8'h05;
    bus_rd(2'b10, d);
    check("R7 mixed read lo", d, 8'hF5);
  endtask

  task automatic t_bitset();
    logic [7:0] d;
    bus_wr(2'b11, 8'h80);
    bus_wr(2'b00, 8'h77);
    bus_wr(2'b01, 8'h66);
    bus_wr(2'b11, 8'h0B);  // bit 5 <- 1
    check("R8 set bit5", pc_o, 8'h20);
    bus_wr(2'b11, 8'h01);  // bit 0 <- 1
    check("R8 set bit0", pc_o, 8'h21);
    bus_wr(2'b11, 8'h0F);  // bit 7 <- 1
    check("R8 set bit7", pc_o, 8'hA1);
    bus_wr(2'b11, 8'h0A);  // bit 5 <- 0
    check("R8 clr bit5", pc_o, 8'h81);
    check("R8 pa kept", pa_o, 8'h77);
    check("R8 pb kept", pb_o, 8'h66);
    check("R8 oe kept", pc_oe_o, 8'hFF);
    bus_rd(2'b11, d);
    check("R8 cfg kept", d, 8'h80);
  endtask

  task automatic t_mode_fields();
    logic [7:0] d;
    bus_wr(2'b11, 8'hE4);
    check("R3 mode_a 11->2", {6'd0, mode_a_o}, 8'h02);
    check("R3 mode_b", {7'd0, mode_b_o}, 8'h01);
    bus_rd(2'b11, d);
    check("R3 cmd readback", d, 8'hC4);
    bus_wr(2'b11, 8'hB2);
    check("R3 mode_a 1", {6'd0, mode_a_o}, 8'h01);
    check("R3 pa_oe in", pa_oe_o, 8'h00);
    check("R3 pb_oe in", pb_oe_o, 8'h00);
    check("R3 pc_oe out", pc_oe_o, 8'hFF);
    bus_rd(2'b11, d);
    check("R3 cmd readback 2", d, 8'hB2);
  endtask

  task automatic t_chip_select();
    logic [7:0] d;
    bus_wr(2'b11, 8'h80);
    bus_wr(2'b00, 8'h42);
    bus_wr(2'b00, 8'h99, 1'b0);
    check("R10 write ignored", pa_o, 8'h42);
    bus_wr(2'b11, 8'h9B, 1'b0);
    check("R10 mode ignored", pa_oe_o, 8'hFF);
    bus_rd(2'b00, d, 1'b0);
    check("R10 rdata zero", d, 8'h00);
    #5 check("R10 idle rdata", rdata_o, 8'h00);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_outputs();
    t_mode_clear();
    t_portc_split();
    t_bitset();
    t_mode_fields();
    t_chip_select();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule